// File: doc/BRIEF.md
# Hashed page table walker

This block resolves a virtual page to a real page when the translation buffer misses. The caller hands it a segment identifier, the offset of the access inside its 256 MB segment and whether the access is a store. The block then searches a page table held in memory. From the segment identifier and the page index it forms a hash, which selects a 64-byte group of eight 8-byte entries. It walks that group one entry at a time through a single 32-bit read port. If no entry in that group matches, it searches a second group selected by the complemented hash. In the first group only entries whose secondary flag is 0 can match; in the second group only entries whose flag is 1 can match.

On a hit the block keeps both words of the entry and forms the real address. It then brings the entry's status bits up to date through a byte-write port. The referenced bit is always set. The changed bit is set only for a store. A load that finds the changed bit clear gets a flag telling the caller to withhold write permission from the translation it caches. Rights checking is left to the caller; the walker only echoes the access type. One walk runs at a time, and a single-cycle `done` pulse closes each walk with either a result or a not-found flag.

Top module: `hpt_walker`

## Requirements
- R1: The page index is offset bits 27:12. The hash is the segment ID XOR the zero-extended page index. The primary group address is table base + ((hash << 6) AND table mask).
- R2: Entry word 0 holds valid at bit 31, the segment ID at bits 30:7, the secondary flag at bit 6 and page-index bits 15:10 at bits 5:0. An entry matches only if it is valid, both fields are equal, and its flag equals the pass (0 primary, 1 secondary).
- R3: Entries of a group are read in order at group + 8*i for i = 0..7. Word 0 (offset +0) is always read first. Word 1 (offset +4) is read only right after a matching word 0, and the search stops at the first match.
- R4: If the primary group holds no match, the group at table base + ((~hash << 6) AND table mask) is searched in the same way with the flag required to be 1.
- R5: A miss in both groups ends the walk with `not_found`=1 and issues no byte write.
- R6: On a hit whose word 1 has the referenced bit (bit 8) clear, one byte write goes to entry + 6 with value word1[15:8] OR 0x01.
- R7: On a store hit whose word 1 has the changed bit (bit 7) clear, one byte write goes to entry + 7 with value word1[7:0] OR 0x80. It is issued after the referenced-bit write when both are needed. No changed-bit write occurs for a load.
- R8: `wr_withheld` is 1 at `done` exactly when the walk hit, the access is a load and the changed bit is clear. `acc_store` echoes the access type.
- R9: On a hit, `pte_w0`/`pte_w1` carry the entry words as read, and `real_addr` = {word1[31:12], offset[11:0]}.
- R10: `done` is a one-cycle pulse that follows the last acknowledged access of the walk. `busy` is high from the cycle after acceptance through the `done` cycle.
- R11: `req_valid` is ignored while `busy` is 1, including in the `done` cycle.
- R12: `rd_req` stays high with a stable `rd_addr` until `rd_ack`. `wr_req` stays high with a stable `wr_addr`/`wr_byte` until `wr_ack`.
- R13: In and right after reset, `busy`, `done`, `rd_req` and `wr_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a walk (taken when idle) |
| req_vsid | input | 24 | Segment identifier of the access |
| req_ea | input | 28 | Offset of the access within its segment |
| req_store | input | 1 | Access is a store |
| tbl_base | input | 32 | Page table base address |
| tbl_mask | input | 32 | Mask applied to the scaled hash |
| busy | output | 1 | Walk in progress |
| rd_req | output | 1 | Word read request |
| rd_addr | output | 32 | Word read address |
| rd_ack | input | 1 | Read acknowledge, data valid |
| rd_data | input | 32 | Read data |
| wr_req | output | 1 | Byte write request |
| wr_addr | output | 32 | Byte write address |
| wr_byte | output | 8 | Byte write data |
| wr_ack | input | 1 | Byte write acknowledge |
| done | output | 1 | Walk finished (one cycle) |
| not_found | output | 1 | No matching entry in either group |
| pte_w0 | output | 32 | Matching entry word 0 |
| pte_w1 | output | 32 | Matching entry word 1 as read |
| real_addr | output | 32 | Translated real address |
| wr_withheld | output | 1 | Caller must not grant write permission |
| acc_store | output | 1 | Access type of the finished walk |

## Verification
A new request can arrive in the same cycle as the walker's closing `done` pulse, or while its status-byte writes are still in flight. The bench provokes both. It pulses `req_valid` part way through a walk, and again on exactly the cycle where `done` is observed. It then judges that the result belongs to the first request, and that no further read starts and `busy` stays low afterwards. The referenced-bit and changed-bit updates of a single store hit fall back to back. The bench checks their order and their addresses and byte values from its own write log. The log is also checked under a slow memory that delays every acknowledge.

// File: rtl/hptw_pkg.sv
package hptw_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_RD0  = 3'd1,
    S_RD1  = 3'd2,
    S_WR_R = 3'd3,
    S_WR_C = 3'd4,
    S_DONE = 3'd5
  } walk_st_t;

  localparam int unsigned WORD_W      = 32;
  localparam int unsigned VALID_BIT   = 31;
  localparam int unsigned REF_BIT     = 8;
  localparam int unsigned CHG_BIT     = 7;
  localparam logic [7:0]  REF_SET     = 8'h01;
  localparam logic [7:0]  CHG_SET     = 8'h80;

endpackage

// File: rtl/hptw_rst_sync.sv
module hptw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/hptw_hash.sv
module hptw_hash #(
  parameter int VSID_W    = 24,
  parameter int PIDX_W    = 16,
  parameter int API_W     = 6,
  parameter int GRP_SHIFT = 6
) (
  input  logic [VSID_W-1:0] vsid,
  input  logic [PIDX_W-1:0] pidx,
  input  logic [31:0]       tbl_base,
  input  logic [31:0]       tbl_mask,
  input  logic              secondary,
  output logic [31:0]       group_addr,
  output logic [31:0]       tag
);
  logic [31:0] hash_p;
  logic [31:0] hash_sel;
  logic [31:0] scaled;

  always_comb begin
    hash_p     = 32'(vsid) ^ 32'(pidx);
    hash_sel   = secondary ? ~hash_p : hash_p;
    scaled     = (hash_sel << GRP_SHIFT) & tbl_mask;
    group_addr = tbl_base + scaled;
    tag        = 32'({vsid, 1'b0, pidx[PIDX_W-1 -: API_W]});
  end
endmodule

// File: rtl/hptw_match.sv
module hptw_match #(
  parameter int API_W = 6
) (
  input  logic [31:0] word,
  input  logic [31:0] tag,
  input  logic        secondary,
  output logic        hit
);
  import hptw_pkg::*;

  localparam int unsigned SEC_BIT = API_W;
  localparam logic [31:0] CMP_MASK = ~((32'd1 << VALID_BIT) | (32'd1 << SEC_BIT));

  always_comb begin
    hit = word[VALID_BIT] && (word[SEC_BIT] == secondary) &&
          ((word & CMP_MASK) == tag);
  end
endmodule

// File: rtl/hptw_update.sv
module hptw_update (
  input  logic [15:0] w1_low,
  input  logic        is_store,
  output logic        need_ref,
  output logic        need_chg,
  output logic [7:0]  ref_byte,
  output logic [7:0]  chg_byte,
  output logic        withhold
);
  import hptw_pkg::*;

  always_comb begin
    need_ref = !w1_low[REF_BIT];
    need_chg = !w1_low[CHG_BIT] && is_store;
    ref_byte = w1_low[15:8] | REF_SET;
    chg_byte = w1_low[7:0] | CHG_SET;
    withhold = !w1_low[CHG_BIT] && !is_store;
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker #(
  parameter int VSID_W        = 24,
  parameter int SEG_BITS      = 28,
  parameter int PAGE_BITS     = 12,
  parameter int GROUP_ENTRIES = 8,
  parameter int PTE_BYTES     = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [VSID_W-1:0]   req_vsid,
  input  logic [SEG_BITS-1:0] req_ea,
  input  logic                req_store,
  input  logic [31:0]         tbl_base,
  input  logic [31:0]         tbl_mask,
  output logic                busy,
  output logic                rd_req,
  output logic [31:0]         rd_addr,
  input  logic                rd_ack,
  input  logic [31:0]         rd_data,
  output logic                wr_req,
  output logic [31:0]         wr_addr,
  output logic [7:0]          wr_byte,
  input  logic                wr_ack,
  output logic                done,
  output logic                not_found,
  output logic [31:0]         pte_w0,
  output logic [31:0]         pte_w1,
  output logic [31:0]         real_addr,
  output logic                wr_withheld,
  output logic                acc_store
);
  import hptw_pkg::*;

  localparam int PIDX_W      = SEG_BITS - PAGE_BITS;
  localparam int API_W       = PIDX_W - 10;
  localparam int IDX_W       = $clog2(GROUP_ENTRIES);
  localparam int ENTRY_SHIFT = $clog2(PTE_BYTES);
  localparam int GRP_SHIFT   = $clog2(GROUP_ENTRIES * PTE_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUP_ENTRIES - 1);
  localparam logic [31:0] W1_OFS  = 32'd4;
  localparam logic [31:0] REF_OFS = 32'(PTE_BYTES - 2);
  localparam logic [31:0] CHG_OFS = 32'(PTE_BYTES - 1);

  logic rst_s;

  walk_st_t            state_q, state_d;
  logic                pass_q, pass_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic                nf_q, nf_d;
  logic                cap_en, w0_en, w1_en;
  logic [VSID_W-1:0]   vsid_q;
  logic [SEG_BITS-1:0] ea_q;
  logic                st_q;
  logic [31:0]         base_q, mask_q;
  logic [31:0]         w0_q, w1_q;

  logic [31:0] group_addr, tag, entry_addr;
  logic        ent_hit;
  logic [15:0] upd_word;
  logic        need_ref, need_chg, withhold;
  logic [7:0]  ref_byte, chg_byte;

  hptw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_s)
  );

  hptw_hash #(
    .VSID_W    (VSID_W),
    .PIDX_W    (PIDX_W),
    .API_W     (API_W),
    .GRP_SHIFT (GRP_SHIFT)
  ) u_hash (
    .vsid       (vsid_q),
    .pidx       (ea_q[SEG_BITS-1:PAGE_BITS]),
    .tbl_base   (base_q),
    .tbl_mask   (mask_q),
    .secondary  (pass_q),
    .group_addr (group_addr),
    .tag        (tag)
  );

  hptw_match #(.API_W(API_W)) u_match (
    .word      (rd_data),
    .tag       (tag),
    .secondary (pass_q),
    .hit       (ent_hit)
  );

  // In the word-1 read cycle the status decision is taken from the bus
  assign upd_word = (state_q == S_RD1) ? rd_data[15:0] : w1_q[15:0];

  hptw_update u_upd (
    .w1_low   (upd_word),
    .is_store (st_q),
    .need_ref (need_ref),
    .need_chg (need_chg),
    .ref_byte (ref_byte),
    .chg_byte (chg_byte),
    .withhold (withhold)
  );

  assign entry_addr = group_addr + (32'(idx_q) << ENTRY_SHIFT);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    pass_d  = pass_q;
    idx_d   = idx_q;
    nf_d    = nf_q;
    cap_en  = 1'b0;
    w0_en   = 1'b0;
    w1_en   = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          cap_en  = 1'b1;
          pass_d  = 1'b0;
          idx_d   = '0;
          nf_d    = 1'b0;
          state_d = S_RD0;
        end
      end
      S_RD0: begin
        if (rd_ack) begin
          w0_en = 1'b1;
          if (ent_hit) begin
            state_d = S_RD1;
          end else if (idx_q == LAST_IDX) begin
            idx_d = '0;
            if (!pass_q) begin
              pass_d = 1'b1;
            end else begin
              nf_d    = 1'b1;
              state_d = S_DONE;
            end
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      S_RD1: begin
        if (rd_ack) begin
          w1_en = 1'b1;
          if (need_ref)      state_d = S_WR_R;
          else if (need_chg) state_d = S_WR_C;
          else               state_d = S_DONE;
        end
      end
      S_WR_R: begin
        if (wr_ack) state_d = need_chg ? S_WR_C : S_DONE;
      end
      S_WR_C: begin
        if (wr_ack) state_d = S_DONE;
      end
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= S_IDLE;
      pass_q  <= 1'b0;
      idx_q   <= '0;
      nf_q    <= 1'b0;
      vsid_q  <= '0;
      ea_q    <= '0;
      st_q    <= 1'b0;
      base_q  <= '0;
      mask_q  <= '0;
      w0_q    <= '0;
      w1_q    <= '0;
    end else begin
      state_q <= state_d;
      pass_q  <= pass_d;
      idx_q   <= idx_d;
      nf_q    <= nf_d;
      if (cap_en) begin
        vsid_q <= req_vsid;
        ea_q   <= req_ea;
        st_q   <= req_store;
        base_q <= tbl_base;
        mask_q <= tbl_mask;
      end
      if (w0_en) w0_q <= rd_data;
      if (w1_en) w1_q <= rd_data;
    end
  end

  // Outputs
  always_comb begin
    busy        = (state_q != S_IDLE);
    rd_req      = (state_q == S_RD0) || (state_q == S_RD1);
    rd_addr     = (state_q == S_RD1) ? entry_addr + W1_OFS : entry_addr;
    wr_req      = (state_q == S_WR_R) || (state_q == S_WR_C);
    wr_addr     = entry_addr + ((state_q == S_WR_C) ? CHG_OFS : REF_OFS);
    wr_byte     = (state_q == S_WR_C) ? chg_byte : ref_byte;
    done        = (state_q == S_DONE);
    not_found   = nf_q;
    pte_w0      = w0_q;
    pte_w1      = w1_q;
    real_addr   = {w1_q[31:PAGE_BITS], ea_q[PAGE_BITS-1:0]};
    wr_withheld = !nf_q && withhold;
    acc_store   = st_q;
  end

  // Assertions
  a_r3_word1_after_match: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == S_RD1) |-> (w0_q[VALID_BIT] && (w0_q[API_W] == pass_q)));

  a_r5_no_write_on_miss: assert property (@(posedge clk) disable iff (!rst_s)
    wr_req |-> !nf_q);

  a_r7_chg_only_store: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == S_WR_C) |-> (st_q && !w1_q[CHG_BIT]));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> (!done && !busy));

  a_r11_busy_holds: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && !done) |=> busy);

  a_r12_rd_hold: assert property (@(posedge clk) disable iff (!rst_s)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

  a_r12_wr_hold: assert property (@(posedge clk) disable iff (!rst_s)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_byte)));

endmodule

// File: tb/sim_hpt_walker.sv
`timescale 1ns/1ps
module sim_hpt_walker;
  localparam logic [31:0] BASE = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_store;
  logic [23:0] req_vsid;
  logic [27:0] req_ea;
  logic [31:0] tbl_base, tbl_mask;
  logic        busy, rd_req, rd_ack, wr_req, wr_ack;
  logic [31:0] rd_addr, rd_data, wr_addr;
  logic [7:0]  wr_byte;
  logic        done, not_found, wr_withheld, acc_store;
  logic [31:0] pte_w0, pte_w1, real_addr;

  always #4 clk = ~clk;

  hpt_walker u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vsid(req_vsid),
    .req_ea(req_ea), .req_store(req_store), .tbl_base(tbl_base), .tbl_mask(tbl_mask),
    .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_byte(wr_byte), .wr_ack(wr_ack),
    .done(done), .not_found(not_found), .pte_w0(pte_w0), .pte_w1(pte_w1),
    .real_addr(real_addr), .wr_withheld(wr_withheld), .acc_store(acc_store)
  );

  logic [31:0] mem [1024];
  int n_chk = 0, n_fail = 0, cyc = 0;
  int lat = 0, rd_wait = 0, wr_wait = 0;
  int rd0_cnt, rd1_cnt, wr_cnt, order_err;
  logic [31:0] last_rd;
  logic [31:0] wlog_a [4];
  logic [7:0]  wlog_b [4];

  function automatic int widx(input logic [31:0] a);
    return int'(((a - BASE) >> 2) & 32'h3FF);
  endfunction

  // memory responder with a configurable acknowledge delay
  always @(posedge clk) begin
    if (!rst_n) begin
      rd_ack <= 1'b0;
      wr_ack <= 1'b0;
      rd_wait = 0;
      wr_wait = 0;
    end else begin
      rd_ack <= 1'b0;
      wr_ack <= 1'b0;
      if (rd_req && !rd_ack) begin
        if (rd_wait >= lat) begin
          rd_ack  <= 1'b1;
          rd_data <= mem[widx(rd_addr)];
          rd_wait = 0;
          if (rd_addr[2]) begin
            rd1_cnt++;
            if (last_rd != rd_addr - 32'd4) order_err++;
          end else begin
            rd0_cnt++;
          end
          last_rd = rd_addr;
        end else begin
          rd_wait++;
        end
      end
      if (wr_req && !wr_ack) begin
        if (wr_wait >= lat) begin
          wr_ack <= 1'b1;
          wr_wait = 0;
          mem[widx(wr_addr)][31 - 8*int'(wr_addr[1:0]) -: 8] <= wr_byte;
          if (wr_cnt < 4) begin
            wlog_a[wr_cnt] = wr_addr;
            wlog_b[wr_cnt] = wr_byte;
          end
          wr_cnt++;
        end else begin
          wr_wait++;
        end
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
        summary();
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // expected-value helpers written from the requirements
  function automatic logic [31:0] grp(input logic [23:0] v, input logic [27:0] ea,
                                      input bit sec);
    logic [31:0] h;
    h = {8'h0, v} ^ {16'h0, ea[27:12]};
    if (sec) h = ~h;
    return BASE + ((h << 6) & tbl_mask);
  endfunction

  function automatic logic [31:0] mkw0(input logic [23:0] v, input logic [27:0] ea,
                                       input bit sec, input bit vld);
    return {vld, v, sec, ea[27:22]};
  endfunction

  function automatic logic [31:0] mkw1(input logic [19:0] rpn, input bit r, input bit c);
    return {rpn, 3'b000, r, c, 5'b00000, 2'b10};
  endfunction

  task automatic clear_all();
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    rd0_cnt = 0; rd1_cnt = 0; wr_cnt = 0; order_err = 0; last_rd = 32'hFFFF_FFFF;
  endtask

  task automatic put(input logic [31:0] a, input logic [31:0] d);
    mem[widx(a)] = d;
  endtask

  task automatic start_walk(input logic [23:0] v, input logic [27:0] ea, input bit st);
    @(negedge clk);
    req_vsid = v; req_ea = ea; req_store = st; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n;
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " done seen"}, {31'd0, done}, 32'd1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_store = 1'b0; req_vsid = '0; req_ea = '0;
    tbl_base = BASE; tbl_mask = 32'h0000_0FC0;
    repeat (4) @(negedge clk);
    chk("R13 busy in reset", {31'd0, busy}, 32'd0);
    chk("R13 rd_req in reset", {31'd0, rd_req}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R13 done after reset", {31'd0, done}, 32'd0);
    chk("R13 wr_req after reset", {31'd0, wr_req}, 32'd0);
  endtask

  task automatic t_load_primary();
    logic [23:0] v = 24'hA5C3_1E;
    logic [27:0] ea = 28'h456_7ABC;
    logic [31:0] g, e, w1;
    clear_all();
    g = grp(v, ea, 0);
    e = g + 32'd24;
    w1 = mkw1(20'hABCDE, 0, 0);
    put(g + 8, mkw0(v, ea ^ 28'h040_0000, 0, 1));   // api differs
    put(g + 16, mkw0(v, ea, 0, 0));                 // invalid
    put(e, mkw0(v, ea, 0, 1));
    put(e + 4, w1);
    start_walk(v, ea, 0);
    chk("R1 busy after accept", {31'd0, busy}, 32'd1);
    wait_done("R10 load");
    chk("R10 busy in done cycle", {31'd0, busy}, 32'd1);
    chk("R5 hit not_found", {31'd0, not_found}, 32'd0);
    chk("R9 pte_w0", pte_w0, mkw0(v, ea, 0, 1));
    chk("R9 pte_w1", pte_w1, w1);
    chk("R9 real_addr", real_addr, {20'hABCDE, ea[11:0]});
    chk("R2 R3 word0 reads", rd0_cnt, 4);
    chk("R3 word1 reads", rd1_cnt, 1);
    chk("R3 read order", order_err, 0);
    chk("R6 write count", wr_cnt, 1);
    chk("R6 ref addr", wlog_a[0], e + 6);
    chk("R6 ref byte", {24'd0, wlog_b[0]}, {24'd0, w1[15:8] | 8'h01});
    chk("R8 withheld on load", {31'd0, wr_withheld}, 32'd1);
    chk("R8 access type", {31'd0, acc_store}, 32'd0);
    @(negedge clk);
    chk("R10 done pulse ends", {30'd0, done, busy}, 32'd0);
  endtask

  task automatic t_store_both();
    logic [23:0] v = 24'h0012_34;
    logic [27:0] ea = 28'hFED_C123;
    logic [31:0] e, w1;
    clear_all();
    e = grp(v, ea, 0);
    w1 = mkw1(20'h13579, 0, 0);
    put(e, mkw0(v, ea, 0, 1));
    put(e + 4, w1);
    start_walk(v, ea, 1);
    wait_done("R7 store");
    chk("R7 write count", wr_cnt, 2);
    chk("R7 first is ref", wlog_a[0], e + 6);
    chk("R7 second addr", wlog_a[1], e + 7);
    chk("R7 chg byte", {24'd0, wlog_b[1]}, {24'd0, w1[7:0] | 8'h80});
    chk("R7 memory word1", mem[widx(e + 4)], w1 | 32'h0000_0180);
    chk("R8 store not withheld", {31'd0, wr_withheld}, 32'd0);
    chk("R8 access type store", {31'd0, acc_store}, 32'd1);
  endtask

  task automatic t_flags_set();
    logic [23:0] v = 24'h3C3C_3C;
    logic [27:0] ea = 28'h0AB_C0DE;
    logic [31:0] e;
    clear_all();
    e = grp(v, ea, 0) + 32'd56;
    put(e, mkw0(v, ea, 0, 1));
    put(e + 4, mkw1(20'h00F0F, 1, 1));
    start_walk(v, ea, 1);
    wait_done("R6 flags set");
    chk("R6 R7 no write when set", wr_cnt, 0);
    chk("R3 last entry reads", rd0_cnt, 8);
    clear_all();
    put(e, mkw0(v, ea, 0, 1));
    put(e + 4, mkw1(20'h00F0F, 0, 1));
    start_walk(v, ea, 0);
    wait_done("R8 chg set");
    chk("R8 load chg set not withheld", {31'd0, wr_withheld}, 32'd0);
    chk("R7 load no chg write", wr_cnt, 1);
  endtask

  task automatic t_secondary();
    logic [23:0] v = 24'h7E01_55;
    logic [27:0] ea = 28'h9A0_5444;
    logic [31:0] gp, gs, w1;
    clear_all();
    gp = grp(v, ea, 0);
    gs = grp(v, ea, 1);
    w1 = mkw1(20'h2468A, 1, 1);
    put(gp + 40, mkw0(v, ea, 1, 1));     // flag 1 in primary: no match
    put(gs + 16, mkw0(v, ea, 0, 1));     // flag 0 in secondary: no match
    put(gs + 56, mkw0(v, ea, 1, 1));
    put(gs + 60, w1);
    start_walk(v, ea, 0);
    wait_done("R4 secondary");
    chk("R4 found", {31'd0, not_found}, 32'd0);
    chk("R2 R4 word0 reads", rd0_cnt, 16);
    chk("R4 word1 reads", rd1_cnt, 1);
    chk("R4 pte_w0", pte_w0, mkw0(v, ea, 1, 1));
    chk("R4 real_addr", real_addr, {20'h2468A, ea[11:0]});
  endtask

  task automatic t_miss();
    clear_all();
    start_walk(24'h11_2233, 28'h765_4321, 1);
    wait_done("R5 miss");
    chk("R5 not_found", {31'd0, not_found}, 32'd1);
    chk("R5 reads", rd0_cnt, 16);
    chk("R5 no word1", rd1_cnt, 0);
    chk("R5 no writes", wr_cnt, 0);
    chk("R8 miss not withheld", {31'd0, wr_withheld}, 32'd0);
  endtask

  task automatic t_mask();
    logic [23:0] v = 24'h00_0FFF;
    logic [27:0] ea = 28'h123_4000;
    logic [31:0] e;
    clear_all();
    tbl_mask = 32'h0000_03C0;
    e = grp(v, ea, 0) + 32'd8;
    put(e, mkw0(v, ea, 0, 1));
    put(e + 4, mkw1(20'h55555, 1, 1));
    start_walk(v, ea, 0);
    wait_done("R1 mask");
    chk("R1 masked group hit", pte_w1, mkw1(20'h55555, 1, 1));
    chk("R1 masked reads", rd0_cnt, 2);
    tbl_mask = 32'h0000_0FC0;
  endtask

  task automatic t_busy_ignore();
    logic [23:0] v = 24'h0A0B_0C;
    logic [27:0] ea = 28'h111_2345;
    logic [31:0] e;
    int rd_snap;
    clear_all();
    e = grp(v, ea, 0) + 32'd16;
    put(e, mkw0(v, ea, 0, 1));
    put(e + 4, mkw1(20'hCAFE0, 0, 1));
    start_walk(v, ea, 0);
    repeat (3) @(negedge clk);
    req_vsid = 24'hFF_FFFF; req_ea = 28'h000_0777; req_store = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done("R11 busy");
    chk("R11 result of first walk", real_addr, {20'hCAFE0, ea[11:0]});
    chk("R11 type of first walk", {31'd0, acc_store}, 32'd0);
    req_valid = 1'b1;                 // coincides with done
    @(negedge clk);
    req_valid = 1'b0;
    rd_snap = rd0_cnt + rd1_cnt;
    repeat (5) @(negedge clk);
    chk("R11 request in done cycle ignored", {31'd0, busy}, 32'd0);
    chk("R11 no new reads", rd0_cnt + rd1_cnt, rd_snap);
  endtask

  task automatic t_slow();
    logic [23:0] v = 24'h5A5A_5A;
    logic [27:0] ea = 28'h2B3_C4D5;
    logic [31:0] e, w1;
    clear_all();
    lat = 3;
    e = grp(v, ea, 0) + 32'd8;
    w1 = mkw1(20'h0BEEF, 0, 0);
    put(e, mkw0(v, ea, 0, 1));
    put(e + 4, w1);
    start_walk(v, ea, 1);
    wait_done("R12 slow");
    chk("R12 slow real_addr", real_addr, {20'h0BEEF, ea[11:0]});
    chk("R12 slow writes", wr_cnt, 2);
    chk("R12 slow chg addr", wlog_a[1], e + 7);
    chk("R12 slow order", order_err, 0);
    lat = 0;
  endtask

  initial begin
    t_reset();
    t_load_primary();
    t_store_both();
    t_flags_set();
    t_secondary();
    t_miss();
    t_mask();
    t_busy_ignore();
    t_slow();
    summary();
  end
endmodule